// File: doc/BRIEF.md
# Floating-point exception and status unit

This block holds the control/status word of a floating-point coprocessor and decides, for each instruction, which exception conditions it records and whether the instruction traps. For every operation the issuing pipeline presents a one-cycle start pulse together with a description of that operation. The description gives the operation kind, the class of each source operand, the class, sign and format of the computed result, and the raw exception indications reported by the arithmetic datapath. For conversions it also gives a rounding-mismatch indication, an integer-range hit flag and the 64-bit integer source.

One cycle after start, the block presents three registered results. The first is a trap request. The second is a write-enable for the destination register, which is withheld whenever the instruction traps. The third is a replacement-result request for subnormal results that are flushed. In that same cycle the status word holds the new cause bits and the updated sticky flags. Software loads the status word through a dedicated write port. A write in the same cycle as a start takes priority over the hardware update.

Top module: `fpx_status_unit`

## Requirements
- R1: After reset the status word reads 0, and the trap, destination write-enable and flush outputs are 0.
- R2: Each IEEE condition uses the same bit order inside every 5-bit group: inexact 0, underflow 1, overflow 2, divide-by-zero 3, invalid 4. The groups sit in the status word as follows: rounding mode in [1:0], flags in [6:2], enables in [11:7], causes in [16:12], the unimplemented cause in bit 17 and flush mode in bit 24. A raised condition sets its cause bit. Its flag is set only when its enable bit is clear.
- R3: One cycle after start, trap is 1 when the unimplemented cause is raised, or when any cause bit meets its set enable bit. Trap is a single-cycle pulse.
- R4: Underflow is accepted only when flush mode is 1 and the underflow and inexact enables are both 0. A raw underflow (raw_exc bit 1) or a subnormal result that is not accepted raises the unimplemented cause instead.
- R5: For an accepted subnormal result (class 2), the underflow and inexact causes are both set and flush_o is 1. In that case flush_val_o takes the smallest normal magnitude when the rounding mode is 2 with a positive sign, or 3 with a negative sign; otherwise it takes zero. The value keeps the result's sign. Single format uses bits [31:0], with a smallest normal of 0x00800000 and the sign in bit 31. Double format uses a smallest normal of 0x0010000000000000 and the sign in bit 63.
- R6: For kind 0 (arithmetic), a quiet-NaN operand (class 4) raises invalid. A signalling-NaN (class 5) or subnormal (class 2) operand raises unimplemented. Operand b is ignored when b_used_i is 0.
- R7: Whenever the unimplemented cause is raised, all five IEEE cause bits read 0 and no flag changes.
- R8: For kind 1 (float to integer), each of the following raises unimplemented: an operand class of 2, 3, 4 or 5, a set range hit, or a raw invalid. Otherwise a set rounding mismatch raises inexact.
- R9: For kind 2 (64-bit integer to float), a signed source of 0x0080000000000000 or above, or below 0xFF80000000000000, raises unimplemented.
- R10: Each start replaces all cause bits. Flags persist across later operations.
- R11: A software write stores only the defined bits (mask 0x0103FFFF). When it falls in the same cycle as a start, the hardware update of that operation is discarded.
- R12: The destination write-enable is 1 one cycle after start exactly when no trap is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle operation strobe |
| op_kind_i | input | 2 | 0 arithmetic, 1 float to integer, 2 long to float, 3 word to float |
| a_cls_i | input | 3 | Operand a class: 0 zero, 1 normal, 2 subnormal, 3 infinity, 4 quiet NaN, 5 signalling NaN |
| b_cls_i | input | 3 | Operand b class, same code |
| b_used_i | input | 1 | Operand b takes part in the operation |
| range_hit_i | input | 1 | Float-to-integer operand magnitude reaches the integer range |
| long_src_i | input | 64 | Integer source of a long-to-float conversion |
| res_cls_i | input | 3 | Result class, same code |
| res_sign_i | input | 1 | Result sign |
| res_dbl_i | input | 1 | Result is double format |
| raw_exc_i | input | 5 | Raw conditions from the datapath, R2 bit order |
| round_diff_i | input | 1 | Rounded integer differs from its source |
| sw_we_i | input | 1 | Software write strobe |
| sw_wdata_i | input | 32 | Software write data |
| csr_o | output | 32 | Control/status word |
| trap_o | output | 1 | Trap request |
| dest_we_o | output | 1 | Destination write-enable |
| flush_o | output | 1 | Replace result with flush_val_o |
| flush_val_o | output | 64 | Flushed replacement value |

## Verification
The bench builds the block with its default parameters: 64-bit results, single and double formats of the usual widths, and an integer range limit of 2 to the 55th. These defaults put both edges of the long-to-float range within reach, at 0x0080000000000000 and 0xFF80000000000000 and at their neighbours one step away. They also give exact flush constants for both formats, so every rounding-mode and sign combination of the flush replacement can be checked against fixed values.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NORM = 3'd1,
    CLS_SUB  = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } fp_cls_e;

  typedef enum logic [1:0] {
    OPK_ARITH    = 2'd0,
    OPK_TOINT    = 2'd1,
    OPK_FROMLONG = 2'd2,
    OPK_FROMWORD = 2'd3
  } op_kind_e;

  localparam int EXC_N = 5;
  localparam int EXC_I = 0;
  localparam int EXC_U = 1;
  localparam int EXC_O = 2;
  localparam int EXC_Z = 3;
  localparam int EXC_V = 4;

  localparam int CSR_W      = 32;
  localparam int RM_LSB     = 0;
  localparam int FLAG_LSB   = 2;
  localparam int EN_LSB     = 7;
  localparam int CAUSE_LSB  = 12;
  localparam int UNIMPL_BIT = 17;
  localparam int FS_BIT     = 24;

  localparam logic [CSR_W-1:0] CSR_MASK =
    (CSR_W'(3) << RM_LSB) |
    (CSR_W'((1 << EXC_N) - 1) << FLAG_LSB) |
    (CSR_W'((1 << EXC_N) - 1) << EN_LSB) |
    (CSR_W'((1 << EXC_N) - 1) << CAUSE_LSB) |
    (CSR_W'(1) << UNIMPL_BIT) |
    (CSR_W'(1) << FS_BIT);
endpackage

// File: rtl/fpx_operand_screen.sv
module fpx_operand_screen
  import fpx_pkg::*;
#(
  parameter int LONG_W    = 64,
  parameter int LIMIT_EXP = 55
) (
  input  logic [1:0]        op_kind_i,
  input  logic [2:0]        a_cls_i,
  input  logic [2:0]        b_cls_i,
  input  logic              b_used_i,
  input  logic              range_hit_i,
  input  logic [LONG_W-1:0] long_src_i,
  output logic              unimpl_o,
  output logic              invalid_o
);
  localparam logic signed [LONG_W-1:0] HI_LIM = LONG_W'(1) << LIMIT_EXP;
  localparam logic signed [LONG_W-1:0] LO_LIM = -HI_LIM;

  op_kind_e kind;
  fp_cls_e  a_cls, b_cls;
  logic     a_bad, b_bad, a_q, b_q, long_out, a_special;

  assign kind  = op_kind_e'(op_kind_i);
  assign a_cls = fp_cls_e'(a_cls_i);
  assign b_cls = fp_cls_e'(b_cls_i);

  assign a_bad     = (a_cls == CLS_SUB) || (a_cls == CLS_SNAN);
  assign b_bad     = b_used_i && ((b_cls == CLS_SUB) || (b_cls == CLS_SNAN));
  assign a_q       = (a_cls == CLS_QNAN);
  assign b_q       = b_used_i && (b_cls == CLS_QNAN);
  assign a_special = (a_cls == CLS_SUB) || (a_cls == CLS_INF) ||
                     (a_cls == CLS_QNAN) || (a_cls == CLS_SNAN);
  assign long_out  = ($signed(long_src_i) >= HI_LIM) || ($signed(long_src_i) < LO_LIM);

  always_comb begin
    unimpl_o  = 1'b0;
    invalid_o = 1'b0;
    case (kind)
      OPK_ARITH: begin
        unimpl_o  = a_bad || b_bad;
        invalid_o = a_q || b_q;
      end
      OPK_TOINT:    unimpl_o = a_special || range_hit_i;
      OPK_FROMLONG: unimpl_o = long_out;
      default:      unimpl_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpx_result_screen.sv
module fpx_result_screen
  import fpx_pkg::*;
#(
  parameter int RES_W   = 64,
  parameter int SP_EXP  = 8,
  parameter int SP_MANT = 23,
  parameter int DP_EXP  = 11,
  parameter int DP_MANT = 52
) (
  input  logic [1:0]       op_kind_i,
  input  logic [EXC_N-1:0] raw_exc_i,
  input  logic             round_diff_i,
  input  logic [2:0]       res_cls_i,
  input  logic             res_sign_i,
  input  logic             res_dbl_i,
  input  logic             fs_i,
  input  logic             en_u_i,
  input  logic             en_i_i,
  input  logic [1:0]       rm_i,
  output logic             unimpl_o,
  output logic [EXC_N-1:0] cause_o,
  output logic             flush_req_o,
  output logic [RES_W-1:0] flush_val_o
);
  localparam logic [RES_W-1:0] SP_MIN  = RES_W'(1) << SP_MANT;
  localparam logic [RES_W-1:0] DP_MIN  = RES_W'(1) << DP_MANT;
  localparam logic [RES_W-1:0] SP_SIGN = RES_W'(1) << (SP_EXP + SP_MANT);
  localparam logic [RES_W-1:0] DP_SIGN = RES_W'(1) << (DP_EXP + DP_MANT);

  logic uf_ok, to_big;

  assign uf_ok = fs_i && !en_u_i && !en_i_i;

  always_comb begin
    unimpl_o    = 1'b0;
    cause_o     = '0;
    flush_req_o = 1'b0;
    if (op_kind_e'(op_kind_i) == OPK_TOINT) begin
      if (raw_exc_i[EXC_V]) unimpl_o = 1'b1;
      else if (round_diff_i) cause_o[EXC_I] = 1'b1;
    end else if (raw_exc_i[EXC_U] && !uf_ok) begin
      unimpl_o = 1'b1;
    end else begin
      cause_o = raw_exc_i;
      if (fp_cls_e'(res_cls_i) == CLS_SUB) begin
        if (!uf_ok) begin
          unimpl_o = 1'b1;
          cause_o  = '0;
        end else begin
          cause_o[EXC_U] = 1'b1;
          cause_o[EXC_I] = 1'b1;
          flush_req_o    = 1'b1;
        end
      end
    end
  end

  assign to_big = ((rm_i == 2'd2) && !res_sign_i) || ((rm_i == 2'd3) && res_sign_i);

  always_comb begin
    flush_val_o = '0;
    if (to_big) flush_val_o = res_dbl_i ? DP_MIN : SP_MIN;
    if (res_sign_i) flush_val_o = flush_val_o | (res_dbl_i ? DP_SIGN : SP_SIGN);
  end
endmodule

// File: rtl/fpx_csr_file.sv
module fpx_csr_file
  import fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             sw_we_i,
  input  logic [CSR_W-1:0] sw_wdata_i,
  input  logic [EXC_N-1:0] cause_i,
  input  logic             unimpl_i,
  output logic [CSR_W-1:0] csr_o
);
  logic [CSR_W-1:0] csr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_q <= '0;
    end else if (sw_we_i) begin
      csr_q <= sw_wdata_i & CSR_MASK;
    end else if (start_i) begin
      csr_q[CAUSE_LSB +: EXC_N] <= cause_i;
      csr_q[UNIMPL_BIT]         <= unimpl_i;
      csr_q[FLAG_LSB +: EXC_N]  <= csr_q[FLAG_LSB +: EXC_N] | (cause_i & ~csr_q[EN_LSB +: EXC_N]);
    end
  end

  assign csr_o = csr_q;

  // R10: flags never clear without a software write
  a_r10_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    !$past(sw_we_i) |-> (($past(csr_q[FLAG_LSB +: EXC_N]) & ~csr_q[FLAG_LSB +: EXC_N]) == '0));

  // R2: a flag only rises where its enable was clear
  a_r2_flag_needs_clear_enable: assert property (@(posedge clk) disable iff (rst)
    !$past(sw_we_i) |->
      ((csr_q[FLAG_LSB +: EXC_N] & ~$past(csr_q[FLAG_LSB +: EXC_N]) & $past(csr_q[EN_LSB +: EXC_N])) == '0));
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
  import fpx_pkg::*;
#(
  parameter int RES_W     = 64,
  parameter int LONG_W    = 64,
  parameter int LIMIT_EXP = 55,
  parameter int SP_EXP    = 8,
  parameter int SP_MANT   = 23,
  parameter int DP_EXP    = 11,
  parameter int DP_MANT   = 52
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        op_kind_i,
  input  logic [2:0]        a_cls_i,
  input  logic [2:0]        b_cls_i,
  input  logic              b_used_i,
  input  logic              range_hit_i,
  input  logic [LONG_W-1:0] long_src_i,
  input  logic [2:0]        res_cls_i,
  input  logic              res_sign_i,
  input  logic              res_dbl_i,
  input  logic [4:0]        raw_exc_i,
  input  logic              round_diff_i,
  input  logic              sw_we_i,
  input  logic [31:0]       sw_wdata_i,
  output logic [31:0]       csr_o,
  output logic              trap_o,
  output logic              dest_we_o,
  output logic              flush_o,
  output logic [RES_W-1:0]  flush_val_o
);
  logic             opd_unimpl, opd_invalid, res_unimpl, flush_req;
  logic [EXC_N-1:0] res_cause, cause_n, en;
  logic [RES_W-1:0] flush_val_n;
  logic             unimpl_n, trap_n;
  logic             trap_q, dest_q, flush_q;
  logic [RES_W-1:0] flush_val_q;

  assign en = csr_o[EN_LSB +: EXC_N];

  fpx_operand_screen #(.LONG_W(LONG_W), .LIMIT_EXP(LIMIT_EXP)) opd_i (
    .op_kind_i   (op_kind_i),
    .a_cls_i     (a_cls_i),
    .b_cls_i     (b_cls_i),
    .b_used_i    (b_used_i),
    .range_hit_i (range_hit_i),
    .long_src_i  (long_src_i),
    .unimpl_o    (opd_unimpl),
    .invalid_o   (opd_invalid)
  );

  fpx_result_screen #(.RES_W(RES_W), .SP_EXP(SP_EXP), .SP_MANT(SP_MANT),
                      .DP_EXP(DP_EXP), .DP_MANT(DP_MANT)) res_i (
    .op_kind_i    (op_kind_i),
    .raw_exc_i    (raw_exc_i),
    .round_diff_i (round_diff_i),
    .res_cls_i    (res_cls_i),
    .res_sign_i   (res_sign_i),
    .res_dbl_i    (res_dbl_i),
    .fs_i         (csr_o[FS_BIT]),
    .en_u_i       (en[EXC_U]),
    .en_i_i       (en[EXC_I]),
    .rm_i         (csr_o[RM_LSB +: 2]),
    .unimpl_o     (res_unimpl),
    .cause_o      (res_cause),
    .flush_req_o  (flush_req),
    .flush_val_o  (flush_val_n)
  );

  assign unimpl_n = opd_unimpl || res_unimpl;
  assign cause_n  = unimpl_n ? '0 : (res_cause | (EXC_N'(opd_invalid) << EXC_V));
  assign trap_n   = unimpl_n || ((cause_n & en) != '0);

  fpx_csr_file csr_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .sw_we_i    (sw_we_i),
    .sw_wdata_i (sw_wdata_i),
    .cause_i    (cause_n),
    .unimpl_i   (unimpl_n),
    .csr_o      (csr_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_q      <= 1'b0;
      dest_q      <= 1'b0;
      flush_q     <= 1'b0;
      flush_val_q <= '0;
    end else begin
      trap_q      <= start_i && trap_n;
      dest_q      <= start_i && !trap_n;
      flush_q     <= start_i && flush_req && !trap_n;
      flush_val_q <= (start_i && flush_req && !trap_n) ? flush_val_n : '0;
    end
  end

  assign trap_o      = trap_q;
  assign dest_we_o   = dest_q;
  assign flush_o     = flush_q;
  assign flush_val_o = flush_val_q;

  // R3: an unimplemented cause recorded by hardware comes with a trap
  a_r3_unimpl_traps: assert property (@(posedge clk) disable iff (rst)
    ($past(start_i) && !$past(sw_we_i) && csr_o[UNIMPL_BIT]) |-> trap_o);

  // R7: unimplemented stands alone in the cause field
  a_r7_unimpl_alone: assert property (@(posedge clk) disable iff (rst)
    ($past(start_i) && !$past(sw_we_i) && csr_o[UNIMPL_BIT]) |-> (csr_o[CAUSE_LSB +: EXC_N] == '0));

  // R12: a trapping instruction never writes its destination
  a_r12_no_write_on_trap: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> !dest_we_o);

  // R3: trap lasts one cycle only when start was not held
  a_r3_trap_pulse: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> $past(start_i));
endmodule

// File: tb/fpx_status_unit_tb_top.sv
module fpx_status_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_i, b_used_i, range_hit_i, res_sign_i, res_dbl_i, round_diff_i, sw_we_i;
  logic [1:0]  op_kind_i;
  logic [2:0]  a_cls_i, b_cls_i, res_cls_i;
  logic [63:0] long_src_i;
  logic [4:0]  raw_exc_i;
  logic [31:0] sw_wdata_i;
  logic [31:0] csr_o;
  logic        trap_o, dest_we_o, flush_o;
  logic [63:0] flush_val_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  fpx_status_unit dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .op_kind_i(op_kind_i),
    .a_cls_i(a_cls_i), .b_cls_i(b_cls_i), .b_used_i(b_used_i),
    .range_hit_i(range_hit_i), .long_src_i(long_src_i), .res_cls_i(res_cls_i),
    .res_sign_i(res_sign_i), .res_dbl_i(res_dbl_i), .raw_exc_i(raw_exc_i),
    .round_diff_i(round_diff_i), .sw_we_i(sw_we_i), .sw_wdata_i(sw_wdata_i),
    .csr_o(csr_o), .trap_o(trap_o), .dest_we_o(dest_we_o), .flush_o(flush_o),
    .flush_val_o(flush_val_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic defaults();
    op_kind_i = 2'd0; a_cls_i = 3'd1; b_cls_i = 3'd1; b_used_i = 1'b1;
    range_hit_i = 1'b0; long_src_i = 64'd0; res_cls_i = 3'd1;
    res_sign_i = 1'b0; res_dbl_i = 1'b0; raw_exc_i = 5'd0; round_diff_i = 1'b0;
  endtask

  task automatic sw_write(input logic [31:0] v);
    @(negedge clk); sw_we_i = 1'b1; sw_wdata_i = v;
    @(negedge clk); sw_we_i = 1'b0;
  endtask

  // issue the prepared operation; returns at the negedge where results are visible
  task automatic fire();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 csr", 64'(csr_o), 64'h0);
    chk("R1 trap", 64'(trap_o), 64'h0);
    chk("R1 dest", 64'(dest_we_o), 64'h0);
    chk("R1 flush", 64'(flush_o), 64'h0);
  endtask

  task automatic t_sw_mask();
    sw_write(32'hFFFF_FFFF);
    chk("R11 mask", 64'(csr_o), 64'h0103_FFFF);
    sw_write(32'h0);
  endtask

  task automatic t_raw_conditions();
    defaults(); sw_write(32'h0);
    raw_exc_i = 5'b00101; fire();
    chk("R2 causes+flags", 64'(csr_o), 64'h5014);
    chk("R3 no trap", 64'(trap_o), 64'h0);
    chk("R12 dest on", 64'(dest_we_o), 64'h1);
    defaults(); fire();
    chk("R10 cause cleared", 64'(csr_o), 64'h14);
    sw_write(32'h200); raw_exc_i = 5'b00100; fire();
    chk("R2 enabled no flag", 64'(csr_o), 64'h4200);
    chk("R3 trap", 64'(trap_o), 64'h1);
    chk("R12 dest off", 64'(dest_we_o), 64'h0);
    @(negedge clk);
    chk("R3 pulse", 64'(trap_o), 64'h0);
    defaults(); raw_exc_i = 5'b11000; sw_write(32'h0); fire();
    chk("R2 Z V", 64'(csr_o), 64'h1_8060);
  endtask

  task automatic t_underflow();
    defaults(); sw_write(32'h0); raw_exc_i = 5'b00011; fire();
    chk("R4 fs off", 64'(csr_o), 64'h2_0000);
    chk("R4 trap", 64'(trap_o), 64'h1);
    sw_write(32'h0100_0080); fire();
    chk("R4 ie set", 64'(csr_o), 64'h0102_0080);
    sw_write(32'h0100_0100); fire();
    chk("R4 ue set", 64'(csr_o), 64'h0102_0100);
    sw_write(32'h0100_0000); raw_exc_i = 5'b00010; fire();
    chk("R4 accepted", 64'(csr_o), 64'h0100_2008);
    chk("R4 no trap", 64'(trap_o), 64'h0);
  endtask

  task automatic t_flush();
    for (int rm = 0; rm < 4; rm++) begin
      for (int s = 0; s < 2; s++) begin
        for (int d = 0; d < 2; d++) begin
          logic [63:0] exp_v;
          defaults(); res_cls_i = 3'd2; res_sign_i = s[0]; res_dbl_i = d[0];
          sw_write(32'h0100_0000 | 32'(rm)); fire();
          exp_v = 64'h0;
          if ((rm == 2 && s == 0) || (rm == 3 && s == 1))
            exp_v = d[0] ? 64'h0010_0000_0000_0000 : 64'h0080_0000;
          if (s == 1) exp_v = exp_v | (d[0] ? 64'h8000_0000_0000_0000 : 64'h8000_0000);
          chk("R5 flush value", flush_val_o, exp_v);
          chk("R5 flush", 64'(flush_o), 64'h1);
          chk("R5 causes", 64'(csr_o), 64'(32'h0100_300C | 32'(rm)));
        end
      end
    end
    defaults(); res_cls_i = 3'd2; sw_write(32'h0); fire();
    chk("R4 subnormal result fs off", 64'(csr_o), 64'h2_0000);
    chk("R4 no flush", 64'(flush_o), 64'h0);
  endtask

  task automatic t_operands();
    defaults(); sw_write(32'h0); a_cls_i = 3'd4; fire();
    chk("R6 qnan invalid", 64'(csr_o), 64'h1_0040);
    defaults(); sw_write(32'h0); b_cls_i = 3'd5; fire();
    chk("R6 snan unimpl", 64'(csr_o), 64'h2_0000);
    defaults(); sw_write(32'h0); b_cls_i = 3'd5; b_used_i = 1'b0; fire();
    chk("R6 b ignored csr", 64'(csr_o), 64'h0);
    chk("R6 b ignored dest", 64'(dest_we_o), 64'h1);
    defaults(); sw_write(32'h0); a_cls_i = 3'd2; fire();
    chk("R6 subnormal unimpl", 64'(csr_o), 64'h2_0000);
    defaults(); sw_write(32'h0); a_cls_i = 3'd4; raw_exc_i = 5'b00011; fire();
    chk("R7 unimpl alone", 64'(csr_o), 64'h2_0000);
  endtask

  task automatic t_toint();
    for (int c = 2; c < 6; c++) begin
      defaults(); op_kind_i = 2'd1; a_cls_i = 3'(c); sw_write(32'h0); fire();
      chk("R8 special operand", 64'(csr_o), 64'h2_0000);
    end
    defaults(); op_kind_i = 2'd1; range_hit_i = 1'b1; sw_write(32'h0); fire();
    chk("R8 range hit", 64'(csr_o), 64'h2_0000);
    defaults(); op_kind_i = 2'd1; raw_exc_i = 5'b10000; sw_write(32'h0); fire();
    chk("R8 raw invalid", 64'(csr_o), 64'h2_0000);
    defaults(); op_kind_i = 2'd1; round_diff_i = 1'b1; sw_write(32'h0); fire();
    chk("R8 inexact", 64'(csr_o), 64'h1004);
  endtask

  task automatic t_long();
    logic [63:0] v [4] = '{64'h0080_0000_0000_0000, 64'h007F_FFFF_FFFF_FFFF,
                           64'hFF80_0000_0000_0000, 64'hFF7F_FFFF_FFFF_FFFF};
    logic [31:0] e [4] = '{32'h2_0000, 32'h0, 32'h0, 32'h2_0000};
    for (int k = 0; k < 4; k++) begin
      defaults(); op_kind_i = 2'd2; long_src_i = v[k]; sw_write(32'h0); fire();
      chk("R9 long range", 64'(csr_o), 64'(e[k]));
    end
  endtask

  task automatic t_priority();
    defaults(); sw_write(32'h0); raw_exc_i = 5'b00001;
    @(negedge clk); start_i = 1'b1; sw_we_i = 1'b1; sw_wdata_i = 32'hFFFF_0003;
    @(negedge clk); start_i = 1'b0; sw_we_i = 1'b0;
    chk("R11 write wins", 64'(csr_o), 64'h0103_0003);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start_i = 1'b0; sw_we_i = 1'b0; sw_wdata_i = 32'h0;
    defaults();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sw_mask();
    t_raw_conditions();
    t_underflow();
    t_flush();
    t_operands();
    t_toint();
    t_long();
    t_priority();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule